// File: doc/BRIEF.md
# Byte-Port Boot Command Interpreter

This block sits behind an 8-bit byte port during early boot. It waits in idle for a command byte and decodes the low nibble of that byte as a command code. It then collects the bytes that the command carries and acts on them. There are four commands. The first hands a memory block read to a separate streamer block. The second loads a 16-word register block. The third records a set of boot parameters. The fourth records a sub-boot number and answers with a fixed confirmation byte.

Bytes come in over a valid/ready handshake. Multi-byte quantities are 16-bit words that arrive low byte first. A flag tells the port whether it is in input mode or output mode. When the block drives the memory streamer, or sends the reply byte, the flag shows output mode and the block accepts no input bytes. When each command finishes, the flag goes back to input mode and the block returns to idle.

Top module: `boot_cmd_interp`

## Requirements
- R1: In idle, every offered byte is accepted, and its bits [3:0] select the command: 1 is memory read, 3 is register block, 4 is boot parameters, 7 is sub-boot. Bits [7:4] are ignored. Any other code is consumed with no effect, and the block stays in idle.
- R2: Each 16-bit word is taken from two successive accepted bytes. The first byte gives bits [7:0] and the second gives bits [15:8].
- R3: The boot-parameter command takes three words for the host address, then one diagnostic byte, then one boot-device byte. Word k goes to host_addr_o[16k+15:16k]. After the boot-device byte the block returns to idle.
- R4: The register-block command takes a block byte and then exactly 16 words. When bits [3:0] of the block byte equal 7, each word gives a one-cycle rblk_we_o pulse in the cycle after its high byte is accepted. The pulse carries the word on rblk_data_o and its index (0 to 15, in arrival order) on rblk_idx_o.
- R5: For any other block number, all 16 words are still consumed, rblk_we_o stays low, and the byte after the 16th word is decoded as a new command.
- R6: The sub-boot command takes one byte and stores it on sub_boot_o. In the next cycle it presents 8'h09 on out_data_o with out_valid_o, in output mode. It holds both until out_ready_i is high, and then returns to input mode and idle.
- R7: The memory-read command takes an address word (address bits [15:0]), then one byte whose bits [1:0] give address bits [17:16], then a count word. In the next cycle it pulses mem_start_o for one cycle with mem_addr_o and mem_count_o. It stays in output mode until mem_done_i, and then returns to idle in input mode.
- R8: in_ready_o is low whenever port_out_mode_o is high, and a byte is accepted only on a cycle where both in_valid_i and in_ready_o are high.
- R9: After reset, every stored parameter is zero, port_out_mode_o is low, in_ready_o is high, and out_valid_o, mem_start_o and rblk_we_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Incoming byte |
| in_valid_i | input | 1 | Incoming byte valid |
| in_ready_o | output | 1 | Block can accept a byte |
| out_data_o | output | 8 | Reply byte |
| out_valid_o | output | 1 | Reply byte valid |
| out_ready_i | input | 1 | Reply byte taken |
| port_out_mode_o | output | 1 | 1 = port in output mode |
| mem_start_o | output | 1 | One-cycle start pulse to the memory streamer |
| mem_addr_o | output | 18 | Start address for the streamer |
| mem_count_o | output | 16 | Word count minus one for the streamer |
| mem_done_i | input | 1 | Streamer has finished |
| rblk_we_o | output | 1 | Register-block word write strobe |
| rblk_idx_o | output | 4 | Register index within the block |
| rblk_data_o | output | 16 | Register write data |
| host_addr_o | output | 48 | Stored host address, first word in the low bits |
| diag_flags_o | output | 8 | Stored diagnostic flags |
| boot_dev_o | output | 8 | Stored boot device |
| sub_boot_o | output | 8 | Stored sub-boot number |

## Verification
The hardest case to observe is a register-block command aimed at a block that cannot be written. The block gives no output to show that it is counting the 16 discarded words. The stimulus sends such a command, then at once sends a boot-parameter command, and checks that every field lands correctly. If the discarded words were consumed too early or too late, that command would be misparsed. A second case holds out_ready_i low for several cycles while the reply is pending. This exposes whether the reply byte and the output-mode flag stay steady under backpressure.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_RD_ALO, S_RD_AHI, S_RD_CNT, S_RD_GO, S_RD_WAIT,
    S_RB_BLK, S_RB_DATA, S_BP_HOST, S_BP_DIAG, S_BP_DEV,
    S_SB_NUM, S_SB_SEND
  } state_e;

  localparam logic [3:0] CMD_MEM_RD   = 4'd1;
  localparam logic [3:0] CMD_REG_BLK  = 4'd3;
  localparam logic [3:0] CMD_BOOT_PAR = 4'd4;
  localparam logic [3:0] CMD_SUB_BOOT = 4'd7;
endpackage

// File: rtl/boot_word_asm.sv
module boot_word_asm #(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                byte_stb_i,
  input  logic [BYTE_W-1:0]   byte_i,
  output logic                word_stb_o,
  output logic [2*BYTE_W-1:0] word_o
);
  logic              have_lo_q;
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_lo_q <= 1'b0;
      lo_q      <= '0;
    end else if (clear_i) begin
      have_lo_q <= 1'b0;
    end else if (byte_stb_i) begin
      if (have_lo_q) begin
        have_lo_q <= 1'b0;
      end else begin
        have_lo_q <= 1'b1;
        lo_q      <= byte_i;
      end
    end
  end

  // word completes on the high byte
  assign word_stb_o = byte_stb_i & have_lo_q & ~clear_i;
  assign word_o     = {byte_i, lo_q};
endmodule

// File: rtl/boot_tx_port.sv
module boot_tx_port #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [BYTE_W-1:0] out_data_o
);
  logic              valid_q;
  logic [BYTE_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      data_q  <= data_i;
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_data_o  = data_q;
endmodule

// File: rtl/boot_param_store.sv
module boot_param_store #(
  parameter int BYTE_W     = 8,
  parameter int WORD_W     = 16,
  parameter int HOST_WORDS = 3,
  localparam int HSEL_W    = (HOST_WORDS > 1) ? $clog2(HOST_WORDS) : 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [WORD_W-1:0]            word_i,
  input  logic [BYTE_W-1:0]            byte_i,
  input  logic                         host_we_i,
  input  logic [HSEL_W-1:0]            host_sel_i,
  input  logic                         diag_we_i,
  input  logic                         dev_we_i,
  input  logic                         sub_we_i,
  output logic [HOST_WORDS*WORD_W-1:0] host_o,
  output logic [BYTE_W-1:0]            diag_o,
  output logic [BYTE_W-1:0]            dev_o,
  output logic [BYTE_W-1:0]            sub_o
);
  logic [WORD_W-1:0] host_q [HOST_WORDS];

  for (genvar g = 0; g < HOST_WORDS; g++) begin : g_host
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                       host_q[g] <= '0;
      else if (host_we_i && host_sel_i == HSEL_W'(g))    host_q[g] <= word_i;
    end
    assign host_o[g*WORD_W +: WORD_W] = host_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_o <= '0;
      dev_o  <= '0;
      sub_o  <= '0;
    end else begin
      if (diag_we_i) diag_o <= byte_i;
      if (dev_we_i)  dev_o  <= byte_i;
      if (sub_we_i)  sub_o  <= byte_i;
    end
  end
endmodule

// File: rtl/boot_cmd_interp.sv
module boot_cmd_interp #(
  parameter int          BYTE_W     = 8,
  parameter int          ADDR_HI_W  = 2,
  parameter int          RBLK_WORDS = 16,
  parameter int          BLK_W      = 4,
  parameter int          RBLK_ID    = 7,
  parameter int          HOST_WORDS = 3,
  parameter logic [7:0]  REPLY      = 8'h09,
  localparam int WORD_W = 2 * BYTE_W,
  localparam int ADDR_W = WORD_W + ADDR_HI_W,
  localparam int IDX_W  = $clog2(RBLK_WORDS),
  localparam int HOST_W = HOST_WORDS * WORD_W,
  localparam int HSEL_W = (HOST_WORDS > 1) ? $clog2(HOST_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              port_out_mode_o,
  output logic              mem_start_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_count_o,
  input  logic              mem_done_i,
  output logic              rblk_we_o,
  output logic [IDX_W-1:0]  rblk_idx_o,
  output logic [WORD_W-1:0] rblk_data_o,
  output logic [HOST_W-1:0] host_addr_o,
  output logic [BYTE_W-1:0] diag_flags_o,
  output logic [BYTE_W-1:0] boot_dev_o,
  output logic [BYTE_W-1:0] sub_boot_o
);
  import boot_cmd_pkg::*;

  state_e              state_q, state_d;
  logic                accept, asm_feed, word_stb;
  logic [WORD_W-1:0]   word;
  logic [ADDR_W-1:0]   addr_q;
  logic [WORD_W-1:0]   cnt_q;
  logic                blk_ok_q;
  logic [IDX_W-1:0]    idx_q;
  logic [HSEL_W-1:0]   hsel_q;
  logic                we_q;
  logic [IDX_W-1:0]    widx_q;
  logic [WORD_W-1:0]   wdata_q;
  logic                tx_load;

  always_comb begin
    unique case (state_q)
      S_RD_GO, S_RD_WAIT, S_SB_SEND: in_ready_o = 1'b0;
      default:                       in_ready_o = 1'b1;
    endcase
  end
  assign port_out_mode_o = (state_q == S_RD_GO) || (state_q == S_RD_WAIT) ||
                           (state_q == S_SB_SEND);
  assign accept   = in_valid_i & in_ready_o;
  assign asm_feed = accept & ((state_q == S_RD_ALO) || (state_q == S_RD_CNT) ||
                              (state_q == S_RB_DATA) || (state_q == S_BP_HOST));

  boot_word_asm #(.BYTE_W(BYTE_W)) i_word_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (state_q == S_IDLE),
    .byte_stb_i (asm_feed),
    .byte_i     (in_data_i),
    .word_stb_o (word_stb),
    .word_o     (word)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (accept) begin
        case (in_data_i[3:0])
          CMD_MEM_RD:   state_d = S_RD_ALO;
          CMD_REG_BLK:  state_d = S_RB_BLK;
          CMD_BOOT_PAR: state_d = S_BP_HOST;
          CMD_SUB_BOOT: state_d = S_SB_NUM;
          default:      state_d = S_IDLE;
        endcase
      end
      S_RD_ALO:  if (word_stb) state_d = S_RD_AHI;
      S_RD_AHI:  if (accept)   state_d = S_RD_CNT;
      S_RD_CNT:  if (word_stb) state_d = S_RD_GO;
      S_RD_GO:                 state_d = S_RD_WAIT;
      S_RD_WAIT: if (mem_done_i) state_d = S_IDLE;
      S_RB_BLK:  if (accept)   state_d = S_RB_DATA;
      S_RB_DATA: if (word_stb && idx_q == IDX_W'(RBLK_WORDS - 1)) state_d = S_IDLE;
      S_BP_HOST: if (word_stb && hsel_q == HSEL_W'(HOST_WORDS - 1)) state_d = S_BP_DIAG;
      S_BP_DIAG: if (accept)   state_d = S_BP_DEV;
      S_BP_DEV:  if (accept)   state_d = S_IDLE;
      S_SB_NUM:  if (accept)   state_d = S_SB_SEND;
      S_SB_SEND: if (out_valid_o && out_ready_i) state_d = S_IDLE;
      default:                 state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      cnt_q    <= '0;
      blk_ok_q <= 1'b0;
      idx_q    <= '0;
      hsel_q   <= '0;
      we_q     <= 1'b0;
      widx_q   <= '0;
      wdata_q  <= '0;
    end else begin
      state_q <= state_d;
      we_q    <= 1'b0;
      if (state_q == S_RD_ALO && word_stb) addr_q[WORD_W-1:0] <= word;
      if (state_q == S_RD_AHI && accept)   addr_q[ADDR_W-1:WORD_W] <= in_data_i[ADDR_HI_W-1:0];
      if (state_q == S_RD_CNT && word_stb) cnt_q <= word;
      if (state_q == S_RB_BLK && accept) begin
        blk_ok_q <= (in_data_i[BLK_W-1:0] == BLK_W'(RBLK_ID));
        idx_q    <= '0;
      end
      if (state_q == S_RB_DATA && word_stb) begin
        idx_q   <= idx_q + 1'b1;
        we_q    <= blk_ok_q;
        widx_q  <= idx_q;
        wdata_q <= word;
      end
      if (state_q == S_IDLE)                    hsel_q <= '0;
      else if (state_q == S_BP_HOST && word_stb) hsel_q <= hsel_q + 1'b1;
    end
  end

  assign mem_start_o = (state_q == S_RD_GO);
  assign mem_addr_o  = addr_q;
  assign mem_count_o = cnt_q;
  assign rblk_we_o   = we_q;
  assign rblk_idx_o  = widx_q;
  assign rblk_data_o = wdata_q;

  boot_param_store #(
    .BYTE_W(BYTE_W), .WORD_W(WORD_W), .HOST_WORDS(HOST_WORDS)
  ) i_params (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word),
    .byte_i     (in_data_i),
    .host_we_i  (state_q == S_BP_HOST && word_stb),
    .host_sel_i (hsel_q),
    .diag_we_i  (state_q == S_BP_DIAG && accept),
    .dev_we_i   (state_q == S_BP_DEV && accept),
    .sub_we_i   (state_q == S_SB_NUM && accept),
    .host_o     (host_addr_o),
    .diag_o     (diag_flags_o),
    .dev_o      (boot_dev_o),
    .sub_o      (sub_boot_o)
  );

  assign tx_load = (state_q == S_SB_NUM) && accept;

  boot_tx_port #(.BYTE_W(BYTE_W)) i_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (tx_load),
    .data_i      (REPLY[BYTE_W-1:0]),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );
endmodule

// File: rtl/boot_cmd_checker.sv
module boot_cmd_checker #(
  parameter int         BYTE_W = 8,
  parameter logic [7:0] REPLY  = 8'h09
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_ready_o,
  input logic              port_out_mode_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              mem_start_o,
  input logic              rblk_we_o
);
  p_no_rx_in_out_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_out_mode_o |-> !in_ready_o);

  p_start_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_start_o |=> !mem_start_o);

  p_start_in_out_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_start_o |-> port_out_mode_o);

  p_reply_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  p_reply_value_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_data_o == REPLY[BYTE_W-1:0] && port_out_mode_o));

  p_we_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rblk_we_o |=> !rblk_we_o);
endmodule

bind boot_cmd_interp boot_cmd_checker #(.BYTE_W(BYTE_W), .REPLY(REPLY)) i_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .in_ready_o      (in_ready_o),
  .port_out_mode_o (port_out_mode_o),
  .out_valid_o     (out_valid_o),
  .out_ready_i     (out_ready_i),
  .out_data_o      (out_data_o),
  .mem_start_o     (mem_start_o),
  .rblk_we_o       (rblk_we_o)
);

// File: tb/test_boot_cmd_interp.sv
`timescale 1ns/1ps
module test_boot_cmd_interp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic        out_mode;
  logic        mem_start;
  logic [17:0] mem_addr;
  logic [15:0] mem_count;
  logic        mem_done = 1'b0;
  logic        rb_we;
  logic [3:0]  rb_idx;
  logic [15:0] rb_data;
  logic [47:0] host;
  logic [7:0]  diag, dev, sub;

  int checks = 0;
  int errors = 0;
  int mon_n = 0;
  int start_n = 0;
  logic [3:0]  mon_idx [32];
  logic [15:0] mon_dat [32];

  always #5 clk = ~clk;

  boot_cmd_interp i_boot_cmd_interp (
    .clk_i(clk), .rst_ni(rst_n),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .port_out_mode_o(out_mode),
    .mem_start_o(mem_start), .mem_addr_o(mem_addr), .mem_count_o(mem_count),
    .mem_done_i(mem_done),
    .rblk_we_o(rb_we), .rblk_idx_o(rb_idx), .rblk_data_o(rb_data),
    .host_addr_o(host), .diag_flags_o(diag), .boot_dev_o(dev), .sub_boot_o(sub)
  );

  always @(negedge clk) begin
    if (rb_we) begin
      if (mon_n < 32) begin
        mon_idx[mon_n] = rb_idx;
        mon_dat[mon_n] = rb_data;
      end
      mon_n++;
    end
    if (mem_start) start_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // called at a negedge, returns at the negedge after acceptance
  task automatic send_byte(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[7:0]);
    send_byte(w[15:8]);
  endtask

  task automatic take_reply(input logic [7:0] exp_sub, input string req);
    chk(out_valid == 1'b1, req, out_valid, 1);
    chk(out_data == 8'h09, req, out_data, 8'h09);
    chk(out_mode == 1'b1 && in_ready == 1'b0, req, {out_mode, in_ready}, 2'b10);
    chk(sub == exp_sub, req, sub, exp_sub);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && out_mode == 1'b0 && in_ready == 1'b1, req,
        {out_valid, out_mode, in_ready}, 3'b001);
  endtask

  task automatic t_reset();
    chk(host == '0 && diag == '0 && dev == '0 && sub == '0, "R9 params", {diag, dev, sub}, 0);
    chk(out_mode == 1'b0 && in_ready == 1'b1, "R9 mode", {out_mode, in_ready}, 2'b01);
    chk(out_valid == 1'b0 && mem_start == 1'b0 && rb_we == 1'b0, "R9 strobes",
        {out_valid, mem_start, rb_we}, 0);
  endtask

  task automatic t_sub_boot();
    send_byte(8'h07);
    send_byte(8'h5A);
    // R6: hold under backpressure
    for (int i = 0; i < 3; i++) begin
      chk(out_valid && out_data == 8'h09 && out_mode, "R6 hold", {out_valid, out_data}, 9'h109);
      @(negedge clk);
    end
    take_reply(8'h5A, "R6");
  endtask

  task automatic t_unknown();
    // R1: 0x02 ignored, 0x17 decoded as code 7
    send_byte(8'h02);
    chk(in_ready == 1'b1 && out_mode == 1'b0, "R1 unknown idle", {in_ready, out_mode}, 2'b10);
    chk(sub == 8'h5A, "R1 unknown no effect", sub, 8'h5A);
    send_byte(8'h17);
    send_byte(8'h33);
    take_reply(8'h33, "R1 high nibble ignored");
  endtask

  task automatic t_boot_par(input logic [15:0] w0, input logic [15:0] w1,
                            input logic [15:0] w2, input logic [7:0] d, input logic [7:0] v);
    send_byte(8'h04);
    send_word(w0);
    send_word(w1);
    send_word(w2);
    send_byte(d);
    send_byte(v);
    chk(host == {w2, w1, w0}, "R3 R2 host address", host, {w2, w1, w0});
    chk(diag == d, "R3 diag", diag, d);
    chk(dev == v, "R3 boot device", dev, v);
    chk(in_ready && !out_mode, "R3 back to idle", {in_ready, out_mode}, 2'b10);
  endtask

  task automatic t_reg_block_w();
    mon_n = 0;
    send_byte(8'h03);
    send_byte(8'hF7);
    for (int k = 0; k < 16; k++) send_word(16'hC000 + 16'(k) * 16'h0101);
    @(negedge clk);
    chk(mon_n == 16, "R4 strobe count", mon_n, 16);
    for (int k = 0; k < 16; k++) begin
      chk(mon_idx[k] == 4'(k) && mon_dat[k] == 16'hC000 + 16'(k) * 16'h0101, "R4 word",
          {mon_idx[k], mon_dat[k]}, {4'(k), 16'hC000 + 16'(k) * 16'h0101});
    end
    // R4: command ended after 16th word
    send_byte(8'h07);
    send_byte(8'h44);
    take_reply(8'h44, "R4 end of block");
  endtask

  task automatic t_reg_block_other();
    mon_n = 0;
    send_byte(8'h03);
    send_byte(8'h05);
    for (int k = 0; k < 16; k++) send_word(16'h0404);
    @(negedge clk);
    chk(mon_n == 0, "R5 no strobe", mon_n, 0);
    t_boot_par(16'hBEEF, 16'h1234, 16'hCAFE, 8'h81, 8'h02);
  endtask

  task automatic t_mem_read();
    start_n = 0;
    send_byte(8'h01);
    send_word(16'h3456);
    send_byte(8'hFE);
    send_word(16'h0010);
    chk(mem_start == 1'b1, "R7 start", mem_start, 1);
    chk(mem_addr == 18'h23456, "R7 address", mem_addr, 18'h23456);
    chk(mem_count == 16'h0010, "R7 count", mem_count, 16'h0010);
    chk(out_mode && !in_ready, "R8 out mode", {out_mode, in_ready}, 2'b10);
    in_valid = 1'b1;
    in_data  = 8'h07;
    repeat (4) @(negedge clk);
    chk(start_n == 1 && out_mode && !in_ready, "R7 R8 wait for done", start_n, 1);
    in_valid = 1'b0;
    mem_done = 1'b1;
    @(negedge clk);
    mem_done = 1'b0;
    chk(!out_mode && in_ready, "R7 back to input", {out_mode, in_ready}, 2'b01);
    chk(sub == 8'h44, "R8 no byte taken in out mode", sub, 8'h44);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sub_boot();
    t_unknown();
    t_boot_par(16'h2211, 16'h4433, 16'h6655, 8'hA5, 8'h3C);
    chk(host == 48'h665544332211, "R2 low byte first", host, 48'h665544332211);
    t_reg_block_w();
    t_reg_block_other();
    t_mem_read();
    finish_run();
  end
endmodule